// File: doc/BRIEF.md
# Paged Virtual Address Translator

This block turns a 13-bit virtual word address into a 12-bit physical main-memory address. An eight-entry page table sits in flip-flops. Each entry holds a 2-bit block number and a presence bit. The top three virtual bits pick an entry. The remaining ten bits are the line offset, which passes straight through to the physical address.

A lookup runs in two stages. On the accepting clock edge, the selected entry and the line offset are latched into a table-buffer stage. On the next edge, the physical address register and the fault flag are loaded, and a one-cycle completion pulse is raised. If the entry is not present, the block reports a page fault instead of an address.

Only one lookup may be in flight at a time. While the block is busy, new requests are dropped. A write port lets system software load or retire a table entry.

Top module: `vpage_xlate`

## Requirements
- R1: After reset, `busy`, `xl_done` and `xl_fault` are 0 and `xl_paddr` is 0.
- R2: After reset, virtual pages 1, 2, 5 and 6 are present in blocks 3, 0, 1 and 2. Pages 0, 3, 4 and 7 are absent.
- R3: The page index is `req_vaddr[12:10]` and the line is `req_vaddr[9:0]`. On a successful lookup, `xl_paddr[9:0]` equals the line.
- R4: A lookup of a present page gives `xl_fault`=0 and `xl_paddr[11:10]` equal to that entry's block number.
- R5: A lookup of an absent page gives `xl_fault`=1 and `xl_paddr`=0.
- R6: A request is accepted on an edge where `req_valid`=1 and `busy`=0. `busy` is 1 for the following cycle. `xl_done` is 1 for exactly the cycle after the next edge, carrying that request's result. `xl_fault` and `xl_paddr` then hold until the next completion.
- R7: A request presented while `busy`=1 is ignored. It produces no completion and does not change the result of the request in flight.
- R8: `wr_en`=1 on an edge stores `wr_block` and `wr_present` into the entry `wr_page`. Lookups accepted on later edges see the new contents.
- R9: A lookup accepted on the same edge as a write to the same entry sees the entry's old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 13 | Virtual word address |
| busy | output | 1 | A lookup is in flight; requests are dropped |
| wr_en | input | 1 | Page table write strobe |
| wr_page | input | 3 | Entry to write |
| wr_block | input | 2 | Block number to store |
| wr_present | input | 1 | Presence bit to store |
| xl_done | output | 1 | One-cycle completion pulse |
| xl_fault | output | 1 | Page fault result of the last lookup |
| xl_paddr | output | 12 | Physical address of the last lookup (0 on fault) |

## Verification
A request accepted on edge k shows `busy` during the cycle after edge k. Its result appears with `xl_done` in the cycle after edge k+1, which is two registers from the request pins. The bench drives and samples on falling edges and counts edges explicitly.

For each lookup it checks `busy` one half-cycle after the accepting edge. It checks `xl_done`, `xl_fault` and `xl_paddr` one half-cycle after the second edge. A further sample one cycle later confirms the pulse has ended and the result is held. Table writes are applied one edge before the lookup they should affect, except in the same-edge case, which is aligned on purpose.

// File: rtl/vpx_pkg.sv
package vpx_pkg;
  localparam int VA_W    = 13;
  localparam int PG_W    = 3;
  localparam int BLK_W   = 2;
  localparam int LINE_W  = VA_W - PG_W;
  localparam int PA_W    = BLK_W + LINE_W;
  localparam int N_PAGES = 1 << PG_W;

  typedef struct packed {
    logic             present;
    logic [BLK_W-1:0] blk;
  } pte_t;

  // physical address = block number above the line offset
  function automatic logic [PA_W-1:0] form_paddr(input logic [BLK_W-1:0] b,
                                                 input logic [LINE_W-1:0] l);
    return {b, l};
  endfunction

  // power-up mapping of the table
  function automatic pte_t reset_entry(input int idx);
    pte_t e;
    e = '0;
    case (idx)
      1: e = '{present: 1'b1, blk: BLK_W'(3)};
      2: e = '{present: 1'b1, blk: BLK_W'(0)};
      5: e = '{present: 1'b1, blk: BLK_W'(1)};
      6: e = '{present: 1'b1, blk: BLK_W'(2)};
      default: e = '0;
    endcase
    return e;
  endfunction
endpackage

// File: rtl/vpx_table.sv
module vpx_table
  import vpx_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [PG_W-1:0] wr_page,
  input  pte_t            wr_pte,
  input  logic [PG_W-1:0] rd_page,
  output pte_t            rd_pte
);
  pte_t entry_q [N_PAGES];

  for (genvar i = 0; i < N_PAGES; i++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        entry_q[i] <= reset_entry(i);
      else if (wr_en && (wr_page == PG_W'(i)))
        entry_q[i] <= wr_pte;
    end
  end

  // read before write: same-edge lookup latches the old entry
  assign rd_pte = entry_q[rd_page];
endmodule

// File: rtl/vpx_tbuf.sv
module vpx_tbuf
  import vpx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  pte_t              rd_pte,
  input  logic [LINE_W-1:0] line_in,
  output logic              s1_vld,
  output pte_t              s1_pte,
  output logic [LINE_W-1:0] s1_line
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld  <= 1'b0;
      s1_pte  <= '0;
      s1_line <= '0;
    end else begin
      s1_vld <= accept;
      if (accept) begin
        s1_pte  <= rd_pte;
        s1_line <= line_in;
      end
    end
  end

  // one lookup in flight: the buffer never holds two back to back
  assert_single_flight_R7: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld |=> !s1_vld);
endmodule

// File: rtl/vpx_assemble.sv
module vpx_assemble
  import vpx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s1_vld,
  input  pte_t              s1_pte,
  input  logic [LINE_W-1:0] s1_line,
  output logic              done,
  output logic              fault,
  output logic [PA_W-1:0]   paddr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done  <= 1'b0;
      fault <= 1'b0;
      paddr <= '0;
    end else begin
      done <= s1_vld;
      if (s1_vld) begin
        fault <= !s1_pte.present;
        paddr <= s1_pte.present ? form_paddr(s1_pte.blk, s1_line) : '0;
      end
    end
  end

  assert_fault_zero_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault) |-> (paddr == '0));

  assert_block_from_buffer_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault) |-> (paddr[PA_W-1:LINE_W] == $past(s1_pte.blk)));

  assert_result_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (fault == $past(fault) && paddr == $past(paddr)));
endmodule

// File: rtl/vpage_xlate.sv
module vpage_xlate
  import vpx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [12:0]      req_vaddr,
  output logic             busy,
  input  logic             wr_en,
  input  logic [2:0]       wr_page,
  input  logic [1:0]       wr_block,
  input  logic             wr_present,
  output logic             xl_done,
  output logic             xl_fault,
  output logic [11:0]      xl_paddr
);
  logic              accept;
  pte_t              rd_pte;
  pte_t              wr_pte;
  logic              s1_vld;
  pte_t              s1_pte;
  logic [LINE_W-1:0] s1_line;

  assign accept = req_valid && !s1_vld;
  assign busy   = s1_vld;
  assign wr_pte = '{present: wr_present, blk: wr_block};

  vpx_table u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_page (wr_page),
    .wr_pte  (wr_pte),
    .rd_page (req_vaddr[VA_W-1:LINE_W]),
    .rd_pte  (rd_pte)
  );

  vpx_tbuf u_tbuf (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .rd_pte  (rd_pte),
    .line_in (req_vaddr[LINE_W-1:0]),
    .s1_vld  (s1_vld),
    .s1_pte  (s1_pte),
    .s1_line (s1_line)
  );

  vpx_assemble u_asm (
    .clk     (clk),
    .rst_n   (rst_n),
    .s1_vld  (s1_vld),
    .s1_pte  (s1_pte),
    .s1_line (s1_line),
    .done    (xl_done),
    .fault   (xl_fault),
    .paddr   (xl_paddr)
  );

  assert_done_follows_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    xl_done |-> $past(busy));

  assert_line_passthrough_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_done && !xl_fault) |-> (xl_paddr[LINE_W-1:0] == $past(req_vaddr[LINE_W-1:0], 2)));
endmodule

// File: tb/sim_vpage_xlate.sv
`timescale 1ns/1ps
module sim_vpage_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [12:0] req_vaddr = '0;
  logic        busy;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_page = '0;
  logic [1:0]  wr_block = '0;
  logic        wr_present = 1'b0;
  logic        xl_done;
  logic        xl_fault;
  logic [11:0] xl_paddr;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  vpage_xlate u0 (.*);

  // vector: {vaddr[12:0], exp_fault, exp_paddr[11:0]}
  localparam int NV = 8;
  localparam logic [25:0] VEC [NV] = '{
    {13'h0555, 1'b0, 12'hD55},   // page 1 -> block 3
    {13'h0BFF, 1'b0, 12'h3FF},   // page 2 -> block 0
    {13'h1400, 1'b0, 12'h400},   // page 5 -> block 1
    {13'h1AAA, 1'b0, 12'hAAA},   // page 6 -> block 2
    {13'h0123, 1'b1, 12'h000},   // page 0 absent
    {13'h0C00, 1'b1, 12'h000},   // page 3 absent
    {13'h10F0, 1'b1, 12'h000},   // page 4 absent
    {13'h1FFF, 1'b1, 12'h000}    // page 7 absent
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at a falling edge; accept edge follows; result after the second edge
  task automatic lookup(input logic [12:0] va, input logic ef, input logic [11:0] ep,
                        input string req);
    req_valid = 1'b1;
    req_vaddr = va;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " R6 busy"}, 32'(busy), 32'd1);
    @(posedge clk);
    @(negedge clk);
    check({req, " R6 done"}, 32'(xl_done), 32'd1);
    check({req, " fault"}, 32'(xl_fault), 32'(ef));
    check({req, " paddr"}, 32'(xl_paddr), 32'(ep));
    @(posedge clk);
    @(negedge clk);
    check({req, " R6 pulse end"}, 32'(xl_done), 32'd0);
    check({req, " R6 held"}, 32'(xl_paddr), 32'(ep));
  endtask

  task automatic write_pte(input logic [2:0] pg, input logic [1:0] b, input logic p);
    wr_en = 1'b1; wr_page = pg; wr_block = b; wr_present = p;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", 32'(busy), 0);
    check("R1 done", 32'(xl_done), 0);
    check("R1 fault", 32'(xl_fault), 0);
    check("R1 paddr", 32'(xl_paddr), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2/R3/R4/R5 against the power-up table
    for (int i = 0; i < NV; i++) begin
      logic [12:0] va;
      logic        ef;
      logic [11:0] ep;
      va = VEC[i][25:13];
      ef = VEC[i][12];
      ep = VEC[i][11:0];
      lookup(va, ef, ep, ef ? "R2 R5 absent" : "R2 R3 R4 present");
    end

    // R8: load page 0 into block 2, retire page 1
    write_pte(3'd0, 2'd2, 1'b1);
    lookup(13'h0123, 1'b0, 12'h923, "R8 new entry");
    write_pte(3'd1, 2'd3, 1'b0);
    lookup(13'h0555, 1'b1, 12'h000, "R8 retired entry");

    // R9: write page 6 absent on the accepting edge -> old mapping used
    wr_en = 1'b1; wr_page = 3'd6; wr_block = 2'd3; wr_present = 1'b0;
    req_valid = 1'b1; req_vaddr = 13'h1AAA;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R9 old done", 32'(xl_done), 1);
    check("R9 old fault", 32'(xl_fault), 0);
    check("R9 old paddr", 32'(xl_paddr), 32'h AAA);
    @(negedge clk);
    lookup(13'h1AAA, 1'b1, 12'h000, "R9 after write");

    // R7: second request presented while busy is dropped
    req_valid = 1'b1; req_vaddr = 13'h1400;
    @(posedge clk);
    @(negedge clk);
    check("R7 busy", 32'(busy), 1);
    req_vaddr = 13'h0BFF;           // still valid during the busy cycle
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R7 first done", 32'(xl_done), 1);
    check("R7 first paddr", 32'(xl_paddr), 32'h400);
    check("R7 not busy", 32'(busy), 0);
    @(posedge clk);
    @(negedge clk);
    check("R7 no extra done", 32'(xl_done), 0);
    @(posedge clk);
    @(negedge clk);
    check("R7 no late done", 32'(xl_done), 0);
    check("R7 result kept", 32'(xl_paddr), 32'h400);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule